// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns one asynchronous serial input line into bytes. A baud generator outside the block supplies a one-cycle enable sixteen times per bit period. On each such tick the receiver samples a synchronised copy of the line. It finds a start bit, collects five to eight data bits least-significant first and an optional parity bit, and then checks the first stop bit. The word length and parity settings are configuration inputs, and the receiver latches them when a start bit is detected. Each finished character goes into a one-entry holding register. The holding register raises `rx_full` and pulses `rx_valid`, and keeps the character until the consumer pulses `rd_ack`.

The controller is a five-state machine:
- IDLE waits for a high-to-low change between two successive tick samples. It moves to START when the carrier input is active.
- START counts eight ticks and samples the line again. A low sample confirms the start bit and the machine moves to DATA. A high sample is a glitch and the machine returns to IDLE.
- DATA samples one bit every sixteen ticks, at mid-bit. After the last configured bit it moves to PARITY if parity is enabled, or to STOP if not.
- PARITY samples the parity bit and moves to STOP.
- STOP samples the first stop bit, hands the character to the holding register and returns to IDLE.

A carrier drop forces a move from any state to IDLE. The character in progress is discarded.

The error indications belong to the character held in the holding register:
- Parity error is set only in the odd and even modes.
- Framing error is set when the stop bit is low.
- Overrun is set when a character arrives while the previous one is still unread. The newer character is discarded.

Top module: `async_rx`

## Requirements
- R1: After reset, `rx_full`, `rx_valid`, `par_err`, `frm_err` and `ovr_err` are 0 and `rx_data` is 0.
- R2: A frame with 8 data bits sent least-significant bit first and no parity is delivered in `rx_data`. `rx_valid` pulses for exactly one clock and `rx_full` rises with it.
- R3: `cfg_wlen` selects the data bit count: 00 selects 8, 01 selects 7, 10 selects 6 and 11 selects 5. Bits of `rx_data` above the selected count read 0.
- R4: With `cfg_par_en`=1, `cfg_par_mode`=00 expects odd parity and 01 expects even parity, counted over the data bits plus the parity bit. A mismatch sets `par_err`.
- R5: With `cfg_par_mode`=10 (mark) or 11 (space), the parity slot is consumed and `par_err` stays 0 whatever value the slot carries.
- R6: A low level sampled at the middle of the first stop bit sets `frm_err`. The data bits are still delivered.
- R7: If a character finishes while `rx_full`=1 and `rd_ack` is 0, then `ovr_err` is set, `rx_data` keeps the older character and `rx_valid` does not pulse.
- R8: A pulse on `rd_ack` clears `rx_full`, `par_err`, `frm_err` and `ovr_err` on the next clock.
- R9: A low pulse shorter than half a bit period on an idle line produces no character. A following valid frame is still received correctly.
- R10: While `carrier_ok` is 0 no character is produced. Dropping `carrier_ok` in the middle of a frame discards that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rx_line | input | 1 | Serial input line, idle high |
| carrier_ok | input | 1 | Carrier present; 0 inhibits reception |
| cfg_wlen | input | 2 | Word length select (00=8, 01=7, 10=6, 11=5) |
| cfg_par_en | input | 1 | Parity slot present |
| cfg_par_mode | input | 2 | 00 odd, 01 even, 10 mark, 11 space |
| rd_ack | input | 1 | Consumer has read the held character |
| rx_data | output | 8 | Held character, upper unused bits zero |
| rx_valid | output | 1 | One-clock pulse when a character is loaded |
| rx_full | output | 1 | Holding register occupied |
| par_err | output | 1 | Parity error for the held character |
| frm_err | output | 1 | Framing error for the held character |
| ovr_err | output | 1 | A character was lost while the holder was full |

## Verification
The hardest paths to reach from the ports are the ones that abandon a frame. One is the START-to-IDLE glitch path. The other is the forced IDLE when the carrier drops in the middle of a frame. For the glitch, the stimulus holds the line low for only four ticks, so the check at eight ticks sees high again. For the carrier drop, the bench cuts `carrier_ok` after three data bits, lets the rest of the frame run past with the carrier off, and restores the carrier only on an idle line. In both cases the bench counts `rx_valid` pulses to prove no character was produced. Overrun is reached by sending two frames in a row with no `rd_ack`.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP  = 3'd4
    } rx_state_t;

    typedef enum logic [1:0] {
        PM_ODD   = 2'b00,
        PM_EVEN  = 2'b01,
        PM_MARK  = 2'b10,
        PM_SPACE = 2'b11
    } par_mode_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_word_t;

    // Index of the last data bit for a word-length code (00 = full width).
    function automatic logic [IDX_W-1:0] last_index(input logic [1:0] wlen);
        return IDX_W'(DATA_W - 1) - IDX_W'(wlen);
    endfunction

    // Parity mismatch; the unused upper data bits are zero, so they do not count.
    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic p,
                                        input par_mode_t mode);
        logic ones_odd;
        ones_odd = (^d) ^ p;
        unique case (mode)
            PM_ODD:  return ~ones_odd;
            PM_EVEN: return ones_odd;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/async_rx_fsm.sv
module async_rx_fsm
    import async_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     os_tick,
    input  logic     rx_s,
    input  logic     carrier_ok,
    input  logic [1:0] cfg_wlen,
    input  logic     cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    output logic     done,
    output rx_word_t word
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OSR - 1);

    rx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic              par_en_q;
    par_mode_t         mode_q;
    logic              prev_q;
    logic [DATA_W-1:0] data_q;
    logic              perr_q;
    logic              ferr_q;
    logic              done_q;

    logic start_edge, half_hit, bit_hit;

    assign start_edge = os_tick && prev_q && !rx_s;
    assign half_hit   = os_tick && (cnt_q == MID_LAST);
    assign bit_hit    = os_tick && (cnt_q == BIT_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!carrier_ok) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:  if (start_edge) state_d = S_START;
                S_START: if (half_hit)   state_d = rx_s ? S_IDLE : S_DATA;
                S_DATA:  if (bit_hit && idx_q == last_q)
                             state_d = par_en_q ? S_PAR : S_STOP;
                S_PAR:   if (bit_hit)    state_d = S_STOP;
                S_STOP:  if (bit_hit)    state_d = S_IDLE;
                default:                 state_d = S_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            idx_q    <= '0;
            last_q   <= '0;
            par_en_q <= 1'b0;
            mode_q   <= PM_ODD;
            prev_q   <= 1'b1;
            data_q   <= '0;
            perr_q   <= 1'b0;
            ferr_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == S_IDLE) begin
                if (os_tick) prev_q <= rx_s;
                if (state_d == S_START) begin
                    cnt_q    <= '0;
                    idx_q    <= '0;
                    last_q   <= last_index(cfg_wlen);
                    par_en_q <= cfg_par_en;
                    mode_q   <= par_mode_t'(cfg_par_mode);
                    data_q   <= '0;
                    perr_q   <= 1'b0;
                    ferr_q   <= 1'b0;
                end
            end else if (carrier_ok && os_tick) begin
                unique case (state_q)
                    S_START: begin
                        if (half_hit) begin
                            cnt_q  <= '0;
                            prev_q <= rx_s;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (bit_hit) begin
                            cnt_q         <= '0;
                            data_q[idx_q] <= rx_s;
                            idx_q         <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (bit_hit) begin
                            cnt_q  <= '0;
                            perr_q <= parity_bad(data_q, rx_s, mode_q);
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (bit_hit) begin
                            cnt_q  <= '0;
                            ferr_q <= ~rx_s;
                            prev_q <= rx_s;
                            done_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign done      = done_q;
    assign word.data = data_q;
    assign word.perr = perr_q;
    assign word.ferr = ferr_q;
endmodule

// File: rtl/async_rx_hold.sv
module async_rx_hold
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  rx_word_t          word,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_full,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err
);
    logic load, lost;

    assign load = done && (!rx_full || rd_ack);
    assign lost = done && rx_full && !rd_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_full  <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
            ovr_err  <= 1'b0;
        end else begin
            rx_valid <= load;
            if (load) begin
                rx_data <= word.data;
                par_err <= word.perr;
                frm_err <= word.ferr;
                rx_full <= 1'b1;
            end else if (rd_ack) begin
                par_err <= 1'b0;
                frm_err <= 1'b0;
                rx_full <= 1'b0;
            end
            if (lost)        ovr_err <= 1'b1;
            else if (rd_ack) ovr_err <= 1'b0;
        end
    end
endmodule

// File: rtl/async_rx.sv
module async_rx
    import async_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic       carrier_ok,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    input  logic       rd_ack,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_full,
    output logic       par_err,
    output logic       frm_err,
    output logic       ovr_err
);
    logic     rx_s;
    logic     done;
    rx_word_t word;

    async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    async_rx_fsm #(.OSR(OSR)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .rx_s        (rx_s),
        .carrier_ok  (carrier_ok),
        .cfg_wlen    (cfg_wlen),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_mode(cfg_par_mode),
        .done        (done),
        .word        (word)
    );

    async_rx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done),
        .word    (word),
        .rd_ack  (rd_ack),
        .rx_data (rx_data),
        .rx_valid(rx_valid),
        .rx_full (rx_full),
        .par_err (par_err),
        .frm_err (frm_err),
        .ovr_err (ovr_err)
    );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       carrier_ok,
    input logic       rd_ack,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_full,
    input logic       par_err,
    input logic       frm_err,
    input logic       ovr_err
);
    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R2
    valid_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_full);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_ack) |=> $stable(rx_data));

    // R8
    ack_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !ovr_err);

    // R4
    perr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> rx_full);

    // R6
    ferr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |-> rx_full);

    // R10
    carrier_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier_ok && $past(!carrier_ok)) |=> !rx_valid);
endmodule

bind async_rx async_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .carrier_ok(carrier_ok),
    .rd_ack    (rd_ack),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_full   (rx_full),
    .par_err   (par_err),
    .frm_err   (frm_err),
    .ovr_err   (ovr_err)
);

// File: tb/async_rx_test.sv
module async_rx_test;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       carrier_ok = 1'b1;
    logic [1:0] cfg_wlen = 2'b00;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'b00;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_full, par_err, frm_err, ovr_err;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    int tick_cnt = 0;

    async_rx uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .carrier_ok(carrier_ok), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
        .cfg_par_mode(cfg_par_mode), .rd_ack(rd_ack), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_full(rx_full), .par_err(par_err),
        .frm_err(frm_err), .ovr_err(ovr_err)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        os_tick  <= (tick_cnt == TICK_DIV - 1);
    end

    always @(posedge clk) if (rx_valid) vcount <= vcount + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic line_bit(input logic v);
        rx_line = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nbits,
                              input logic has_par, input logic pbit,
                              input logic stop_v);
        line_bit(1'b0);
        for (int i = 0; i < nbits; i++) line_bit(d[i]);
        if (has_par) line_bit(pbit);
        line_bit(stop_v);
        line_bit(1'b1);
        line_bit(1'b1);
    endtask

    task automatic ack();
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 full", rx_full, 0);
        chk("R1 valid", rx_valid, 0);
        chk("R1 errs", {par_err, frm_err, ovr_err}, 0);
        chk("R1 data", rx_data, 0);
    endtask

    task automatic t_basic();
        int v0 = vcount;
        cfg_wlen = 2'b00; cfg_par_en = 1'b0;
        send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b1);
        chk("R2 data", rx_data, 8'hA5);
        chk("R2 full", rx_full, 1);
        chk("R2 one valid pulse", vcount - v0, 1);
        chk("R2 no errs", {par_err, frm_err, ovr_err}, 0);
        ack();
        chk("R8 full cleared", rx_full, 0);
        send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1);
        chk("R2 data second", rx_data, 8'h3C);
        ack();
    endtask

    task automatic t_wlen();
        cfg_wlen = 2'b11;
        send_frame(8'hF5, 5, 1'b0, 1'b0, 1'b1);
        chk("R3 5-bit upper zero", rx_data, 8'h15);
        ack();
        cfg_wlen = 2'b10;
        send_frame(8'hFF, 6, 1'b0, 1'b0, 1'b1);
        chk("R3 6-bit", rx_data, 8'h3F);
        ack();
        cfg_wlen = 2'b01;
        send_frame(8'hD5, 7, 1'b0, 1'b0, 1'b1);
        chk("R3 7-bit", rx_data, 8'h55);
        ack();
        cfg_wlen = 2'b00;
    endtask

    task automatic t_parity();
        cfg_par_en = 1'b1;
        cfg_par_mode = 2'b00;
        send_frame(8'hA5, 8, 1'b1, 1'b1, 1'b1);
        chk("R4 odd good", par_err, 0);
        chk("R4 odd data", rx_data, 8'hA5);
        ack();
        send_frame(8'hA5, 8, 1'b1, 1'b0, 1'b1);
        chk("R4 odd bad", par_err, 1);
        ack();
        chk("R8 perr cleared", par_err, 0);
        cfg_par_mode = 2'b01;
        send_frame(8'hA5, 8, 1'b1, 1'b0, 1'b1);
        chk("R4 even good", par_err, 0);
        ack();
        send_frame(8'h07, 8, 1'b1, 1'b0, 1'b1);
        chk("R4 even bad", par_err, 1);
        ack();
        cfg_par_mode = 2'b10;
        send_frame(8'hA5, 8, 1'b1, 1'b0, 1'b1);
        chk("R5 mark slot low", par_err, 0);
        chk("R5 mark data", rx_data, 8'hA5);
        ack();
        cfg_par_mode = 2'b11;
        send_frame(8'h5A, 8, 1'b1, 1'b1, 1'b1);
        chk("R5 space slot high", par_err, 0);
        chk("R5 space data", rx_data, 8'h5A);
        ack();
        cfg_par_en = 1'b0;
        cfg_par_mode = 2'b00;
    endtask

    task automatic t_framing();
        send_frame(8'h81, 8, 1'b0, 1'b0, 1'b0);
        chk("R6 frm_err", frm_err, 1);
        chk("R6 data kept", rx_data, 8'h81);
        ack();
        chk("R8 ferr cleared", frm_err, 0);
        send_frame(8'h42, 8, 1'b0, 1'b0, 1'b1);
        chk("R6 recover data", rx_data, 8'h42);
        chk("R6 recover no ferr", frm_err, 0);
        ack();
    endtask

    task automatic t_overrun();
        int v0 = vcount;
        send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1);
        send_frame(8'h22, 8, 1'b0, 1'b0, 1'b1);
        chk("R7 ovr set", ovr_err, 1);
        chk("R7 old data kept", rx_data, 8'h11);
        chk("R7 single valid", vcount - v0, 1);
        ack();
        chk("R8 ovr cleared", ovr_err, 0);
        chk("R8 full cleared after ovr", rx_full, 0);
    endtask

    task automatic t_glitch();
        int v0 = vcount;
        rx_line = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R9 glitch no byte", vcount - v0, 0);
        chk("R9 glitch not full", rx_full, 0);
        send_frame(8'h6E, 8, 1'b0, 1'b0, 1'b1);
        chk("R9 after glitch", rx_data, 8'h6E);
        ack();
    endtask

    task automatic t_carrier();
        int v0 = vcount;
        carrier_ok = 1'b0;
        send_frame(8'h99, 8, 1'b0, 1'b0, 1'b1);
        chk("R10 no carrier no byte", vcount - v0, 0);
        carrier_ok = 1'b1;
        line_bit(1'b1);
        line_bit(1'b0);
        line_bit(1'b1);
        line_bit(1'b0);
        line_bit(1'b0);
        carrier_ok = 1'b0;
        for (int i = 0; i < 5; i++) line_bit(1'b1);
        line_bit(1'b1);
        carrier_ok = 1'b1;
        line_bit(1'b1);
        chk("R10 mid-frame drop", vcount - v0, 0);
        chk("R10 not full", rx_full, 0);
        send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b1);
        chk("R10 carrier restored", rx_data, 8'hC3);
        ack();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        line_bit(1'b1);
        t_basic();
        t_wlen();
        t_parity();
        t_framing();
        t_overrun();
        t_glitch();
        t_carrier();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule